// File: doc/BRIEF.md
# Single-Cycle 16-bit Accumulator Processor Core

This core runs one instruction per clock. It has no fetch register. The word on the instruction input is decoded in the same cycle that the program counter drives its address. The core holds three registers: an address/data register A, a data register D and a 16-bit program counter. Data memory is reached only through A. The memory operand M is the data word at the address held in A, and the same register gives the branch target. Instruction memory and data memory sit outside the core.

There are two classes of instruction, selected by bit 15, and each one completes in a single cycle. The first class loads an immediate into A. The second class is a compute instruction. It feeds D and either A or M into a combinational ALU, writes the result to any mix of A, D and M, and may load the program counter from A, depending on the sign of the result. The decoder names the two classes `K_LOAD_A` and `K_COMPUTE`. Each cycle moves from the current class to whichever class the next word carries, and no other sequencing exists. Reset is synchronous: it clears the registers and stops writes, so data memory keeps its contents.

Top module: `cpu16_core`

## Requirements
- R1: `instr_addr` equals bits [14:0] of the program counter, and the word on `instr` drives the outputs within the same cycle, with no register in between.
- R2: When `instr[15]` is 0, A takes `{1'b0, instr[14:0]}` at the clock edge, `mem_we` stays low, and D does not change.
- R3: In a compute instruction, `instr[11:6]` selects the ALU function, applied in this order: bit 11 zeroes x, bit 10 inverts x, bit 9 zeroes y, bit 8 inverts y, bit 7 chooses add (1) or bitwise AND (0), and bit 6 inverts the result. `mem_wdata` carries the result.
- R4: The x operand is always D. The y operand is A when `instr[12]` is 0, and `mem_rdata` when it is 1. `mem_addr` equals A[14:0].
- R5: The destination bits are `instr[5]` for A, `instr[4]` for D and `instr[3]` for M. A and D update at the edge, and `mem_we` is high for the whole cycle when bit 3 is set.
- R6: The jump bits are `instr[2]` for less than zero, `instr[1]` for equal to zero and `instr[0]` for greater than zero. When a set bit matches the result, the PC loads the value that A held before this instruction.
- R7: When no jump is taken, or when the instruction loads A, the PC increments by one.
- R8: The result counts as zero exactly when all 16 bits are 0, and as negative exactly when bit 15 is 1. The two conditions never hold at once.
- R9: While `rst` is high, each clock edge clears the PC, A and D, and `mem_we` is held low. When `rst` falls, execution starts at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_addr | output | 15 | Instruction memory address (PC[14:0]) |
| instr | input | 16 | Instruction word for the current cycle |
| mem_addr | output | 15 | Data memory address (A[14:0]) |
| mem_rdata | input | 16 | Data word at `mem_addr` (operand M) |
| mem_wdata | output | 16 | ALU result, written when `mem_we` is high |
| mem_we | output | 1 | Data memory write enable for this cycle |

## Verification
The bench builds the core with its default widths: a 16-bit word and a 15-bit instruction address, the only layout the instruction encoding supports. At these widths the bench can sweep all 64 ALU function codes, for six operand triples and both y sources. It also runs all eight jump codes against negative, zero and positive results, and all eight destination combinations. Each case checks the current-cycle outputs and, on the following cycle, the resulting PC, A and D.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

    localparam int FN_W    = 6;
    localparam int JMP_W   = 3;
    localparam int FN_LSB  = 6;
    localparam int YSEL_BIT = 12;
    localparam int DST_A_BIT = 5;
    localparam int DST_D_BIT = 4;
    localparam int DST_M_BIT = 3;

    typedef enum logic {
        K_LOAD_A  = 1'b0,
        K_COMPUTE = 1'b1
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic              y_from_mem;
        logic [FN_W-1:0]   fn;
        logic              wr_a;
        logic              wr_d;
        logic              wr_m;
        logic [JMP_W-1:0]  jmp;
    } ctrl_t;

endpackage

// File: rtl/cpu16_decode.sv
module cpu16_decode
    import cpu16_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] instr,
    output ctrl_t             ctrl,
    output logic [WORD_W-1:0] imm
);

    localparam int KIND_BIT = WORD_W - 1;

    kind_e kind;

    always_comb begin
        kind = kind_e'(instr[KIND_BIT]);
        ctrl = '0;
        imm  = '0;
        unique case (kind)
            K_LOAD_A: begin
                ctrl.kind = K_LOAD_A;
                imm       = {1'b0, instr[KIND_BIT-1:0]};
            end
            K_COMPUTE: begin
                ctrl.kind       = K_COMPUTE;
                ctrl.y_from_mem = instr[YSEL_BIT];
                ctrl.fn         = instr[FN_LSB +: FN_W];
                ctrl.wr_a       = instr[DST_A_BIT];
                ctrl.wr_d       = instr[DST_D_BIT];
                ctrl.wr_m       = instr[DST_M_BIT];
                ctrl.jmp        = instr[JMP_W-1:0];
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
    import cpu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]    x,
    input  logic [W-1:0]    y,
    input  logic [FN_W-1:0] fn,
    output logic [W-1:0]    res,
    output logic            zr,
    output logic            ng
);

    localparam int N_OPND = 2;

    logic [N_OPND-1:0][W-1:0] opnd_raw;
    logic [N_OPND-1:0][W-1:0] opnd_cond;
    logic [W-1:0]             core_out;

    assign opnd_raw[0] = x;
    assign opnd_raw[1] = y;

    // Operand conditioning: fn[5]/fn[4] act on x, fn[3]/fn[2] on y.
    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        localparam int ZERO_BIT = FN_W - 1 - 2 * g;
        localparam int INV_BIT  = FN_W - 2 - 2 * g;
        logic [W-1:0] zeroed;
        assign zeroed       = fn[ZERO_BIT] ? '0 : opnd_raw[g];
        assign opnd_cond[g] = fn[INV_BIT] ? ~zeroed : zeroed;
    end

    always_comb begin
        core_out = fn[1] ? (opnd_cond[0] + opnd_cond[1])
                         : (opnd_cond[0] & opnd_cond[1]);
        res = fn[0] ? ~core_out : core_out;
        zr  = (res == '0);
        ng  = res[W-1];
    end

endmodule

// File: rtl/cpu16_branch.sv
module cpu16_branch
    import cpu16_pkg::*;
(
    input  logic [JMP_W-1:0] jmp,
    input  logic             zr,
    input  logic             ng,
    output logic             take
);

    logic lt, eq, gt;

    always_comb begin
        lt   = ng;
        eq   = zr;
        gt   = !zr && !ng;
        take = (jmp[2] && lt) || (jmp[1] && eq) || (jmp[0] && gt);
    end

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
    import cpu16_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int IADDR_W = 15
) (
    input  logic               clk,
    input  logic               rst,
    output logic [IADDR_W-1:0] instr_addr,
    input  logic [WORD_W-1:0]  instr,
    output logic [IADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic [WORD_W-1:0]  mem_wdata,
    output logic               mem_we
);

    localparam logic [WORD_W-1:0] PC_INC = WORD_W'(1);

    logic [WORD_W-1:0] a_q, d_q, pc_q;
    ctrl_t             ctrl;
    logic [WORD_W-1:0] imm;
    logic [WORD_W-1:0] alu_y, alu_res;
    logic              alu_zr, alu_ng, take;

    cpu16_decode #(.WORD_W(WORD_W)) u_dec (
        .instr (instr),
        .ctrl  (ctrl),
        .imm   (imm)
    );

    assign alu_y = ctrl.y_from_mem ? mem_rdata : a_q;

    cpu16_alu #(.W(WORD_W)) u_alu (
        .x   (d_q),
        .y   (alu_y),
        .fn  (ctrl.fn),
        .res (alu_res),
        .zr  (alu_zr),
        .ng  (alu_ng)
    );

    cpu16_branch u_br (
        .jmp  (ctrl.jmp),
        .zr   (alu_zr),
        .ng   (alu_ng),
        .take (take)
    );

    // Register process.
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q  <= '0;
            d_q  <= '0;
            pc_q <= '0;
        end else begin
            unique case (ctrl.kind)
                K_LOAD_A: begin
                    a_q <= imm;
                end
                K_COMPUTE: begin
                    if (ctrl.wr_a) a_q <= alu_res;
                    if (ctrl.wr_d) d_q <= alu_res;
                end
                default: ;
            endcase
            pc_q <= take ? a_q : pc_q + PC_INC;
        end
    end

    // Output process.
    always_comb begin
        instr_addr = pc_q[IADDR_W-1:0];
        mem_addr   = a_q[IADDR_W-1:0];
        mem_wdata  = alu_res;
        mem_we     = !rst && (ctrl.kind == K_COMPUTE) && ctrl.wr_m;
    end

    assert_loada_R2: assert property (@(posedge clk) disable iff (rst)
        (ctrl.kind == K_LOAD_A) |=> a_q == {1'b0, $past(instr[WORD_W-2:0])})
        else $error("A immediate load wrong");

    assert_loada_nowrite_R2: assert property (@(posedge clk) disable iff (rst)
        (ctrl.kind == K_LOAD_A) |-> !mem_we)
        else $error("write during A load");

    assert_jump_target_R6: assert property (@(posedge clk) disable iff (rst)
        take |=> pc_q == $past(a_q))
        else $error("taken jump missed target");

    assert_pc_step_R7: assert property (@(posedge clk) disable iff (rst)
        !take |=> pc_q == $past(pc_q) + PC_INC)
        else $error("PC did not step");

    assert_flags_excl_R8: assert property (@(posedge clk) disable iff (rst)
        alu_zr |-> !alu_ng)
        else $error("zero and negative together");

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (pc_q == '0 && a_q == '0 && d_q == '0))
        else $error("reset did not clear registers");

    assert_reset_nowrite_R9: assert property (@(posedge clk)
        rst |-> !mem_we)
        else $error("write during reset");

endmodule

// File: tb/cpu16_core_tb.sv
module cpu16_core_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] instr_addr;
    logic [15:0] instr = 16'h0000;
    logic [14:0] mem_addr;
    logic [15:0] mem_rdata = 16'h0000;
    logic [15:0] mem_wdata;
    logic        mem_we;

    int checks = 0;
    int errors = 0;

    // Bench model of architectural state.
    logic [15:0] m_a, m_d, m_pc;
    string       pc_tag = "R7";

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu16_core u_dut (
        .clk        (clk),
        .rst        (rst),
        .instr_addr (instr_addr),
        .instr      (instr),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] alu_ref(input logic [15:0] x, input logic [15:0] y, input logic [5:0] f);
        logic [15:0] xx, yy, o;
        xx = f[5] ? 16'h0000 : x;
        if (f[4]) xx = ~xx;
        yy = f[3] ? 16'h0000 : y;
        if (f[2]) yy = ~yy;
        o = f[1] ? xx + yy : xx & yy;
        if (f[0]) o = ~o;
        return o;
    endfunction

    // Drive one instruction at a falling edge, check mid-cycle, then advance.
    task automatic run(input logic [15:0] ins, input string tag);
        logic [15:0] r, y;
        logic        take;
        instr = ins;
        #(CLK_PERIOD/4);
        chk(instr_addr == m_pc[14:0], pc_tag, {1'b0, instr_addr}, m_pc);     // R1
        chk(mem_addr == m_a[14:0], "R4", {1'b0, mem_addr}, m_a);
        if (!ins[15]) begin
            chk(mem_we == 1'b0, "R2", {15'b0, mem_we}, 16'h0);
            m_a  = {1'b0, ins[14:0]};
            m_pc = m_pc + 16'd1;
            pc_tag = "R7";
        end else begin
            y = ins[12] ? mem_rdata : m_a;                                     // R4
            r = alu_ref(m_d, y, ins[11:6]);
            chk(mem_wdata == r, tag, mem_wdata, r);
            chk(mem_we == ins[3], "R5", {15'b0, mem_we}, {15'b0, ins[3]});
            take = (ins[2] && r[15]) || (ins[1] && r == 16'h0) ||
                   (ins[0] && !r[15] && r != 16'h0);
            m_pc   = take ? m_a : m_pc + 16'd1;
            pc_tag = take ? "R6" : "R7";
            if (ins[5]) m_a = r;
            if (ins[4]) m_d = r;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] cmp(input logic a, input logic [5:0] fn,
                                        input logic [2:0] dst, input logic [2:0] j);
        return {3'b111, a, fn, dst, j};
    endfunction

    localparam logic [5:0] FN_Y    = 6'b110000;
    localparam logic [5:0] FN_NY   = 6'b110001;
    localparam logic [5:0] FN_X    = 6'b001100;
    localparam logic [5:0] FN_ADD  = 6'b000010;
    localparam logic [5:0] FN_ZERO = 6'b101010;
    localparam logic [5:0] FN_ONE  = 6'b111111;
    localparam logic [5:0] FN_MONE = 6'b111010;

    logic [14:0] d_src [6] = '{15'h0000, 15'h0001, 15'h1234, 15'h7FFF, 15'h0005, 15'h0000};
    logic        d_neg [6] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    logic [14:0] a_val [6] = '{15'h0000, 15'h0001, 15'h0F0F, 15'h7FFF, 15'h0003, 15'h4000};
    logic [15:0] m_val [6] = '{16'h0000, 16'h0002, 16'h8001, 16'hFFFF, 16'h5555, 16'h7FFE};

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R9: reset with an M-writing compute word on the bus.
        rst   = 1'b1;
        instr = cmp(1'b0, FN_ONE, 3'b001, 3'b111);
        repeat (3) @(negedge clk);
        chk(mem_we == 1'b0, "R9", {15'b0, mem_we}, 16'h0);
        chk(instr_addr == 15'h0, "R9", {1'b0, instr_addr}, 16'h0);
        chk(mem_addr == 15'h0, "R9", {1'b0, mem_addr}, 16'h0);
        rst  = 1'b0;
        m_a  = 16'h0; m_d = 16'h0; m_pc = 16'h0;
        pc_tag = "R9";

        // R3 / R4: every ALU function, both y sources, several operand triples.
        for (int p = 0; p < 6; p++) begin
            run({1'b0, d_src[p]}, "R3");
            run(cmp(1'b0, d_neg[p] ? FN_NY : FN_Y, 3'b010, 3'b000), "R3");
            run({1'b0, a_val[p]}, "R2");
            mem_rdata = m_val[p];
            for (int f = 0; f < 64; f++) begin
                run(cmp(1'b0, 6'(f), 3'b000, 3'b000), "R3");
                run(cmp(1'b1, 6'(f), 3'b000, 3'b000), "R4");
            end
        end

        // R5: all destination combinations, read D back through the ALU.
        mem_rdata = 16'h0101;
        for (int dst = 0; dst < 8; dst++) begin
            run(16'h0022, "R2");
            run(cmp(1'b0, FN_Y, 3'b010, 3'b000), "R5");
            run(16'h0013, "R2");
            run(cmp(1'b1, FN_ADD, 3'(dst), 3'b000), "R5");
            run(cmp(1'b0, FN_X, 3'b000, 3'b000), "R5");
        end

        // R6 / R7 / R8: every jump code against negative, zero and positive results.
        for (int j = 0; j < 8; j++) begin
            for (int s = 0; s < 3; s++) begin
                run(16'h0100 + 16'(j * 4 + s), "R2");
                run(cmp(1'b0, (s == 0) ? FN_MONE : (s == 1) ? FN_ZERO : FN_ONE,
                        3'b000, 3'(j)), "R8");
                run(16'h0000, "R2");
            end
        end

        // R6: jump target is A before the same instruction overwrites A.
        run(16'h0456, "R2");
        run(cmp(1'b0, FN_ONE, 3'b100, 3'b111), "R6");
        run(16'h0001, "R2");

        // R9: mid-run reset clears state and restarts at 0.
        run(16'h0077, "R2");
        run(cmp(1'b0, FN_Y, 3'b010, 3'b000), "R5");
        rst   = 1'b1;
        instr = cmp(1'b0, FN_ONE, 3'b001, 3'b000);
        #(CLK_PERIOD/4);
        chk(mem_we == 1'b0, "R9", {15'b0, mem_we}, 16'h0);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        rst  = 1'b0;
        m_a  = 16'h0; m_d = 16'h0; m_pc = 16'h0;
        pc_tag = "R9";
        run(cmp(1'b0, FN_X, 3'b000, 3'b000), "R9");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule